// File: doc/BRIEF.md
# Shadow-Backed SRAM Store and Recall Controller

This block is the control core of a byte-wide static RAM that keeps a nonvolatile twin of every location. Strobes in the style of an asynchronous part (chip select, output enable, write enable and a bidirectional store line), sampled on a system clock, are decoded into read and write cycles on the working array. The block also runs the two bulk transfers: a save copies the whole working array into the shadow copy, and a restore copies the shadow copy back. Each transfer is atomic and covers every location at once.

A save can be started by a falling edge on the store line, by a rising edge on a digital power-fail flag, or by reading a fixed six-address key sequence. The first two are skipped when nothing has been written since the last transfer. The key sequence always saves. A second key sequence starts a restore, and a restore also runs by itself after every reset. While a transfer runs, all accesses are locked out. During a save the block pulls the store line low, modelled as an open-drain drive enable.

The depth is 2^ADDR_W bytes. ADDR_W = 13 gives the full 8192-byte part, and the default is kept small so that elaboration stays light. Key addresses are 13-bit constants and are truncated to ADDR_W bits.

Top module: `nvs_ctrl`

## Requirements
- R1: `dq_oe` is high, and `dq_out` shows the byte stored at `addr`, only while `ce_n`=0, `oe_n`=0, `we_n`=1, `hsb_n`=1 and no transfer is running. Otherwise `dq_oe` is 0.
- R2: A write window is open while `ce_n`=0, `we_n`=0 and `hsb_n`=1. The byte is committed when `ce_n` or `we_n` returns high, using the address and data present in the last cycle of the window.
- R3: The array holds 2^ADDR_W bytes of 8 bits each, and every address from 0 to 2^ADDR_W-1 can be reached.
- R4: No read drives the bus and no write changes the array while a save or restore is in progress.
- R5: A falling edge on `hsb_n` while idle and dirty starts a save. `hsb_pull_low` is then high for exactly STORE_CYC cycles.
- R6: A falling edge on `hsb_n` or a rising edge on `pwr_fail` is ignored when no write has been committed since the last completed save or restore.
- R7: A rising edge on `pwr_fail` while idle and dirty starts a save of STORE_CYC cycles.
- R8: Six consecutive read cycles at addresses 0x0A5A, 0x15A5, 0x0F0F, 0x10F0, 0x0333, 0x1CCC (each taken mod 2^ADDR_W) start a save whether or not the array is dirty. A read at any other address, or a committed write, restarts the match.
- R9: The sequence 0x0A5A, 0x15A5, 0x0F0F, 0x10F0, 0x0333, 0x1C3C (mod 2^ADDR_W) starts a restore that overwrites every working byte with its shadow value.
- R10: After reset, a restore runs before any access is accepted. The shadow copy is not cleared by reset, so saved data reappears in the working array.
- R11: While `we_n`=0 the output drive is off, even when `oe_n`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset, treated as power-up |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| hsb_n | input | 1 | Sensed level of the store line; a falling edge requests a save |
| pwr_fail | input | 1 | Digital power-fail flag; a rising edge requests a save |
| addr | input | ADDR_W | Byte address |
| dq_in | input | 8 | Write data |
| dq_out | output | 8 | Read data, valid while dq_oe is high |
| dq_oe | output | 1 | Output drive enable for the data bus |
| hsb_pull_low | output | 1 | Open-drain pull-down on the store line while a save runs |

## Verification
The hardest case to reach is data that survives a reset. A byte has to be written, saved into the shadow copy, overwritten in the working array, and then come back only through the restore that follows reset. The stimulus saves with the key sequence first, then dirties the working byte, pulses reset, and reads the byte after the automatic restore. A near-miss key sequence, broken by one wrong address just before the final key, shows that the matcher restarts instead of triggering.

// File: rtl/nvs_pkg.sv
// Shared types and constants for the shadow-backed SRAM controller.
// Assumes ADDR_W <= KEY_W in every user of key_addr().
package nvs_pkg;

    typedef enum logic [1:0] {
        OP_BOOT   = 2'd0,
        OP_IDLE   = 2'd1,
        OP_STORE  = 2'd2,
        OP_RECALL = 2'd3
    } op_state_e;

    localparam int KEY_LEN = 6;
    localparam int KEY_W   = 13;

    // Key address idx of list 0 (save) or list 1 (restore); only the last step differs.
    function automatic logic [KEY_W-1:0] key_addr(input int list, input int idx);
        logic [KEY_W-1:0] k;
        case (idx)
            0:       k = 13'h0A5A;
            1:       k = 13'h15A5;
            2:       k = 13'h0F0F;
            3:       k = 13'h10F0;
            4:       k = 13'h0333;
            default: k = (list == 0) ? 13'h1CCC : 13'h1C3C;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/nvs_access.sv
// Access decoder: turns the sampled strobes into a read-enable, a read event
// for the key matchers, and a single-cycle write commit at the end of a write
// window. Assumes the strobes are already synchronous to clk.
module nvs_access #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              hsb_n,
    input  logic              busy,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rd_act,
    output logic              rd_ev,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    logic              wr_act;
    logic              wr_act_q;
    logic              rd_act_q;
    logic [ADDR_W-1:0] rd_addr_q;

    // Cycle decode: reads need write and store lines idle; both are blocked while busy.
    always_comb begin
        rd_act = !ce_n && !oe_n && we_n && hsb_n && !busy;
        wr_act = !ce_n && !we_n && hsb_n && !busy;
    end

    // Track the last cycle of each window, holding the newest write address and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_act_q  <= 1'b0;
            rd_act_q  <= 1'b0;
            rd_addr_q <= '0;
            wr_addr   <= '0;
            wr_data   <= '0;
        end else begin
            wr_act_q  <= wr_act;
            rd_act_q  <= rd_act;
            rd_addr_q <= addr;
            if (wr_act) begin
                wr_addr <= addr;
                wr_data <= dq_in;
            end
        end
    end

    // Commit on window close by ce_n/we_n; a close caused by the store line aborts.
    always_comb begin
        wr_en = wr_act_q && !wr_act && (ce_n || we_n) && hsb_n && !busy;
        rd_ev = rd_act && (!rd_act_q || (addr != rd_addr_q));
    end

endmodule

// File: rtl/nvs_key_match.sv
// Key-sequence matcher: advances one step per read event whose address equals
// the expected key, restarts on any other address or on clear, and pulses hit
// on the read that completes the list. LIST selects which key list is used.
module nvs_key_match
    import nvs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LIST   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              rd_ev,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);

    localparam int STEP_W = $clog2(KEY_LEN);

    logic [STEP_W-1:0] step_q;
    logic              match_cur;
    logic              match_first;
    logic              at_last;

    // Low ADDR_W bits of a key entry.
    function automatic logic [ADDR_W-1:0] key_low(input int idx);
        logic [KEY_W-1:0] full;
        full = key_addr(LIST, idx);
        return full[ADDR_W-1:0];
    endfunction

    // Compare the current address with the expected and first keys.
    always_comb begin
        match_cur   = (addr == key_low(int'(step_q)));
        match_first = (addr == key_low(0));
        at_last     = (step_q == STEP_W'(KEY_LEN - 1));
        hit         = rd_ev && match_cur && at_last;
    end

    // Step register: advance on a match, restart (or re-enter step 1) on a miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
        end else if (clear) begin
            step_q <= '0;
        end else if (rd_ev) begin
            if (match_cur) begin
                step_q <= at_last ? '0 : step_q + STEP_W'(1);
            end else begin
                step_q <= match_first ? STEP_W'(1) : '0;
            end
        end
    end

endmodule

// File: rtl/nvs_op_seq.sv
// Transfer sequencer: owns the dirty flag and the save/restore state machine.
// It runs the power-up restore, decides whether a save request is honoured,
// times each transfer with one down-counter, and pulses the bulk copy
// strobes (restore copy at start, save copy on the final cycle).
module nvs_op_seq
    import nvs_pkg::*;
#(
    parameter int STORE_CYC  = 2_000_000,
    parameter int RECALL_CYC = 4_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hsb_n,
    input  logic pwr_fail,
    input  logic wr_en,
    input  logic sw_store,
    input  logic sw_recall,
    output logic busy,
    output logic store_active,
    output logic do_recall,
    output logic do_store_copy
);

    localparam int MAX_CYC = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    op_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             dirty_q;
    logic             hsb_q;
    logic             pf_q;
    logic             hw_req;
    logic             pf_req;
    logic             dirty_eff;
    logic             start_store;
    logic             finish;

    // Request edges and the save/restore start decisions.
    always_comb begin
        hw_req        = hsb_q && !hsb_n;
        pf_req        = pwr_fail && !pf_q;
        dirty_eff     = dirty_q || wr_en;
        start_store   = (state_q == OP_IDLE) && !sw_recall &&
                        (sw_store || ((hw_req || pf_req) && dirty_eff));
        do_recall     = (state_q == OP_BOOT) || ((state_q == OP_IDLE) && sw_recall);
        finish        = ((state_q == OP_STORE) || (state_q == OP_RECALL)) && (cnt_q == '0);
        do_store_copy = (state_q == OP_STORE) && (cnt_q == '0);
        busy          = (state_q != OP_IDLE);
        store_active  = (state_q == OP_STORE);
    end

    // State machine and transfer timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OP_BOOT;
            cnt_q   <= '0;
        end else if (do_recall) begin
            state_q <= OP_RECALL;
            cnt_q   <= CNT_W'(RECALL_CYC - 1);
        end else if (start_store) begin
            state_q <= OP_STORE;
            cnt_q   <= CNT_W'(STORE_CYC - 1);
        end else if (finish) begin
            state_q <= OP_IDLE;
        end else if (busy) begin
            cnt_q   <= cnt_q - CNT_W'(1);
        end
    end

    // Dirty flag and edge-detect history; a completed transfer cleans the array.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dirty_q <= 1'b0;
            hsb_q   <= 1'b1;
            pf_q    <= 1'b0;
        end else begin
            hsb_q <= hsb_n;
            pf_q  <= pwr_fail;
            if (finish) begin
                dirty_q <= 1'b0;
            end else if (wr_en) begin
                dirty_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/nvs_ctrl.sv
// Top level: working array plus shadow array, joined by bulk copy paths.
// Assumes ADDR_W <= 13 and synchronous strobes. The shadow array is left
// unreset on purpose, because it models storage that survives power loss.
module nvs_ctrl #(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 8,
    parameter int STORE_CYC  = 2_000_000,
    parameter int RECALL_CYC = 4_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              hsb_n,
    input  logic              pwr_fail,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              hsb_pull_low
);

    localparam int DEPTH   = 1 << ADDR_W;
    localparam int N_LISTS = 2;

    logic [DATA_W-1:0] sram   [DEPTH];
    logic [DATA_W-1:0] shadow [DEPTH];

    logic               busy;
    logic               store_active;
    logic               do_recall;
    logic               do_store_copy;
    logic               rd_act;
    logic               rd_ev;
    logic               wr_en;
    logic [ADDR_W-1:0]  wr_addr;
    logic [DATA_W-1:0]  wr_data;
    logic [N_LISTS-1:0] key_hit;

    nvs_access #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_access (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n    (ce_n),
        .oe_n    (oe_n),
        .we_n    (we_n),
        .hsb_n   (hsb_n),
        .busy    (busy),
        .addr    (addr),
        .dq_in   (dq_in),
        .rd_act  (rd_act),
        .rd_ev   (rd_ev),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    // One matcher per key list: list 0 saves, list 1 restores.
    for (genvar g = 0; g < N_LISTS; g++) begin : g_key
        nvs_key_match #(.ADDR_W(ADDR_W), .LIST(g)) u_match (
            .clk   (clk),
            .rst_n (rst_n),
            .clear (wr_en || busy),
            .rd_ev (rd_ev),
            .addr  (addr),
            .hit   (key_hit[g])
        );
    end

    nvs_op_seq #(.STORE_CYC(STORE_CYC), .RECALL_CYC(RECALL_CYC)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .hsb_n         (hsb_n),
        .pwr_fail      (pwr_fail),
        .wr_en         (wr_en),
        .sw_store      (key_hit[0]),
        .sw_recall     (key_hit[1]),
        .busy          (busy),
        .store_active  (store_active),
        .do_recall     (do_recall),
        .do_store_copy (do_store_copy)
    );

    // Working array: a bulk restore has priority over a single-byte write.
    always_ff @(posedge clk) begin
        if (do_recall) begin
            for (int i = 0; i < DEPTH; i++) sram[i] <= shadow[i];
        end else if (wr_en) begin
            sram[wr_addr] <= wr_data;
        end
    end

    // Shadow array: captured in full on the final cycle of a save.
    always_ff @(posedge clk) begin
        if (do_store_copy) begin
            for (int i = 0; i < DEPTH; i++) shadow[i] <= sram[i];
        end
    end

    // Output drive and open-drain busy indication.
    always_comb begin
        dq_oe        = rd_act;
        dq_out       = rd_act ? sram[addr] : '0;
        hsb_pull_low = store_active;
    end

endmodule

// File: rtl/nvs_ctrl_chk.sv
// Checker for nvs_ctrl: bus ownership, lockout, save length and the
// power-up restore. Attached to every nvs_ctrl instance by the bind below.
module nvs_ctrl_chk #(
    parameter int STORE_CYC = 2_000_000
) (
    input logic clk,
    input logic rst_n,
    input logic ce_n,
    input logic oe_n,
    input logic we_n,
    input logic hsb_n,
    input logic dq_oe,
    input logic hsb_pull_low,
    input logic busy,
    input logic wr_en
);

    logic [31:0] run_q;

    // Length of the current pull-low run.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= hsb_pull_low ? run_q + 32'd1 : '0;
    end

    assert_read_decode_R1: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (!ce_n && !oe_n && we_n && hsb_n));

    assert_no_drive_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !dq_oe);

    assert_no_write_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !wr_en);

    assert_store_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hsb_pull_low) |-> (run_q == 32'(STORE_CYC)));

    assert_boot_recall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> busy);

    assert_we_tristate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !dq_oe);

endmodule

bind nvs_ctrl nvs_ctrl_chk #(.STORE_CYC(STORE_CYC)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .ce_n         (ce_n),
    .oe_n         (oe_n),
    .we_n         (we_n),
    .hsb_n        (hsb_n),
    .dq_oe        (dq_oe),
    .hsb_pull_low (hsb_pull_low),
    .busy         (busy),
    .wr_en        (wr_en)
);

// File: tb/nvs_ctrl_tb_top.sv
// Self-checking bench for nvs_ctrl: a vector table of writes and read-backs,
// then directed tests of saves, restores, lockout and reset persistence.
module nvs_ctrl_tb_top;

    localparam int ADDR_W     = 8;
    localparam int STORE_CYC  = 20;
    localparam int RECALL_CYC = 8;

    // Vector table: {address, data}.
    localparam logic [15:0] VEC [8] = '{
        16'h003C, 16'h01A7, 16'h0200, 16'h7FFF,
        16'h8081, 16'hFE5A, 16'hFFC3, 16'h1024
    };
    localparam logic [7:0] KEY_HEAD [5] = '{8'h5A, 8'hA5, 8'h0F, 8'hF0, 8'h33};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ce_n = 1'b1;
    logic              oe_n = 1'b1;
    logic              we_n = 1'b1;
    logic              hsb_n = 1'b1;
    logic              pwr_fail = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        dq_in = '0;
    logic [7:0]        dq_out;
    logic              dq_oe;
    logic              hsb_pull_low;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    nvs_ctrl #(.ADDR_W(ADDR_W), .STORE_CYC(STORE_CYC), .RECALL_CYC(RECALL_CYC)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .ce_n         (ce_n),
        .oe_n         (oe_n),
        .we_n         (we_n),
        .hsb_n        (hsb_n),
        .pwr_fail     (pwr_fail),
        .addr         (addr),
        .dq_in        (dq_in),
        .dq_out       (dq_out),
        .dq_oe        (dq_oe),
        .hsb_pull_low (hsb_pull_low)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; dq_in = d; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d, output logic oe);
        @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
        #1; d = dq_out; oe = dq_oe;
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
    endtask

    // Counts consecutive negedges with the pull-down high, from the current one.
    task automatic pull_len(output int n);
        n = 0;
        while (hsb_pull_low && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic hsb_pulse(output int n);
        @(negedge clk); hsb_n = 1'b0;
        @(negedge clk); hsb_n = 1'b1;
        pull_len(n);
    endtask

    task automatic pf_pulse(output int n);
        @(negedge clk); pwr_fail = 1'b1;
        @(negedge clk); pwr_fail = 1'b0;
        pull_len(n);
    endtask

    task automatic key_seq(input logic [7:0] last);
        logic [7:0] d;
        logic       oe;
        for (int k = 0; k < 5; k++) rd(KEY_HEAD[k], d, oe);
        rd(last, d, oe);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        idle(3);
        chk("R10 reset oe", int'(dq_oe), 0);
        chk("R10 reset pull", int'(hsb_pull_low), 0);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        logic [7:0] d;
        logic       oe;
        int         n;

        do_reset();
        // R10: immediately after reset the restore locks out reads.
        rd(8'h00, d, oe);
        chk("R10 boot lockout", int'(oe), 0);
        idle(RECALL_CYC + 4);

        // R2/R3/R1: table walk, writes then read-backs including both ends.
        foreach (VEC[i]) wr(VEC[i][15:8], VEC[i][7:0]);
        foreach (VEC[i]) begin
            rd(VEC[i][15:8], d, oe);
            chk("R1 read oe", int'(oe), 1);
            chk("R2 R3 read data", int'(d), int'(VEC[i][7:0]));
        end

        // R11: we_n low with oe_n low keeps the bus undriven (the cycle also writes).
        @(negedge clk); addr = 8'h40; dq_in = 8'h77; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
        #1; chk("R11 we low no drive", int'(dq_oe), 0);
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        rd(8'h40, d, oe);
        chk("R2 write on close", int'(d), 8'h77);

        // R5: dirty store-line save with exact length.
        hsb_pulse(n);
        chk("R5 save length", n, STORE_CYC);

        // R6: clean array ignores the store line and the power-fail flag.
        hsb_pulse(n);
        chk("R6 clean hsb ignored", n, 0);
        pf_pulse(n);
        chk("R6 clean pwr_fail ignored", n, 0);

        // R7: a write makes the array dirty, then power-fail saves.
        wr(8'h41, 8'h12);
        pf_pulse(n);
        chk("R7 pwr_fail save length", n, STORE_CYC);

        // R4: accesses during a save have no effect.
        wr(8'h42, 8'h34);
        @(negedge clk); hsb_n = 1'b0;
        @(negedge clk); hsb_n = 1'b1;
        chk("R5 pull during save", int'(hsb_pull_low), 1);
        rd(8'h01, d, oe);
        chk("R4 no read while busy", int'(oe), 0);
        wr(8'h01, 8'hEE);
        idle(STORE_CYC + 4);
        rd(8'h01, d, oe);
        chk("R4 write blocked", int'(d), 8'hA7);

        // R8: key sequence saves even when clean.
        key_seq(8'hCC);
        pull_len(n);
        chk("R8 key save length", n, STORE_CYC);

        // R8: wrong address before the last key restarts the match.
        for (int k = 0; k < 5; k++) rd(KEY_HEAD[k], d, oe);
        rd(8'h34, d, oe);
        rd(8'hCC, d, oe);
        pull_len(n);
        chk("R8 broken sequence ignored", n, 0);

        // R9: the restore key brings back the saved byte and locks out reads.
        wr(8'h00, 8'h99);
        key_seq(8'h3C);
        rd(8'h00, d, oe);
        chk("R9 restore lockout", int'(oe), 0);
        idle(RECALL_CYC + 4);
        rd(8'h00, d, oe);
        chk("R9 restored data", int'(d), 8'h3C);

        // R10: an unsaved overwrite is lost across reset; shadow data returns.
        wr(8'h00, 8'h55);
        rd(8'h00, d, oe);
        chk("R2 overwrite visible", int'(d), 8'h55);
        do_reset();
        idle(RECALL_CYC + 4);
        rd(8'h00, d, oe);
        chk("R10 shadow survives reset", int'(d), 8'h3C);
        rd(8'hFF, d, oe);
        chk("R10 R3 top address restored", int'(d), 8'hC3);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule